// File: doc/BRIEF.md
# Byte Table Lookup Permute Unit

This unit assembles a 64-bit result by picking bytes out of a short table. The table is made of one to four 64-bit words that sit next to each other in a local register file. A descriptor names the first word of the table and how many words it has. Each of the eight result lanes takes one index byte from an index word. The index byte selects a word of the table and a byte inside that word. If the index is past the end of the table, that lane takes its byte from a default word instead.

Tables are loaded through a register-file write port. Lookups use a valid/ready request and return a registered result one cycle later, together with a single-cycle response valid. The register file has a power-of-two depth, and table word numbers wrap around its end. All eight lanes are resolved in the same lookup.

Top module: `byte_perm_lookup`

## Requirements
- R1: While reset is asserted and right after it, `rsp_valid` is low, `rsp_data` is zero, and every register-file word reads as zero.
- R2: `req_ready` is held high. A lookup is accepted in each cycle where `req_valid` and `req_ready` are both high.
- R3: `rsp_valid` is high in exactly the cycle after an accepted lookup, and low after any cycle without one.
- R4: The table length in words is `req_desc[1:0]` plus one, so the index limit is that count times 8. The table's first word number is `req_desc[6:2]`.
- R5: For lane k (index byte `req_index[8k+7:8k]`) with an index below the limit, the source word is first word + (index >> 3). The source byte is number (index & 7) of that word, where byte 0 is bits [7:0]. That byte goes to `rsp_data[8k+7:8k]`.
- R6: For lane k with an index equal to or greater than the limit, `rsp_data[8k+7:8k]` equals `req_default[8k+7:8k]`.
- R7: Source word numbers are taken modulo 32, so a table that starts near word 31 continues at word 0.
- R8: A register write with `wr_en` high updates word `wr_addr` at the clock edge. A lookup accepted in the same cycle still sees the old contents, and later lookups see the new value.
- R9: `rsp_data` keeps its value through cycles that follow a cycle with no accepted lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register-file write strobe |
| wr_addr | input | 5 | Word number to write |
| wr_data | input | 64 | Write data |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request ready |
| req_desc | input | 7 | [6:2] first word, [1:0] word count minus one |
| req_index | input | 64 | Eight index bytes, lane k in bits [8k+7:8k] |
| req_default | input | 64 | Fallback bytes for out-of-range lanes |
| rsp_valid | output | 1 | Result valid pulse |
| rsp_data | output | 64 | Lookup result |

## Verification
The bench tests indices right at the limit for each table length (7/8, 15/16, 23/24, 31/32) and the index 255. An off-by-one limit would return a table byte where the default byte is expected, or the other way round. A table that starts at word 30 with four words checks the modulo-32 wrap; a design that did not wrap would read the wrong word or an undefined one. A lookup issued in the same cycle as a write to its own table must return the old byte, which exposes a write-through path. Random lookups with mixed in-range and out-of-range lanes catch lane mix-ups and byte-order swaps.

// File: rtl/byte_perm_lookup.sv
module byte_perm_lookup #(
  parameter int NREGS = 32,
  parameter int LEN_W = 2,
  localparam int AW = $clog2(NREGS),
  localparam int DESC_W = LEN_W + AW,
  localparam int LANES = 8,
  localparam int DW = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DESC_W-1:0] req_desc,
  input  logic [DW-1:0]     req_index,
  input  logic [DW-1:0]     req_default,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data
);
  logic [DW-1:0] rf [NREGS];
  logic [AW-1:0] base;
  logic [31:0]   limit;
  logic [DW-1:0] result;
  logic          accept;

  assign req_ready = 1'b1;
  assign accept    = req_valid && req_ready;
  assign base      = req_desc[DESC_W-1:LEN_W];
  assign limit     = (32'(req_desc[LEN_W-1:0]) + 32'd1) << 3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else if (wr_en) begin
      rf[wr_addr] <= wr_data;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [7:0]    idx;
    logic [AW-1:0] src;
    logic [DW-1:0] word;
    logic          in_range;

    assign idx      = req_index[8*k +: 8];
    assign src      = base + AW'(idx >> 3);
    assign word     = rf[src];
    assign in_range = 32'(idx) < limit;
    assign result[8*k +: 8] = in_range ? word[{idx[2:0], 3'b000} +: 8]
                                       : req_default[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) rsp_data <= result;
    end
  end
endmodule

// File: rtl/byte_perm_lookup_chk.sv
module byte_perm_lookup_chk #(
  parameter int DESC_W = 7,
  parameter int LEN_W = 2,
  parameter int DW = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [DESC_W-1:0] req_desc,
  input logic [DW-1:0]     req_index,
  input logic [DW-1:0]     req_default,
  input logic              rsp_valid,
  input logic [DW-1:0]     rsp_data
);
  logic [31:0] lim;
  assign lim = (32'(req_desc[LEN_W-1:0]) + 32'd1) * 32'd8;

  p_ready_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_ready);

  p_rsp_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_rsp_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(rsp_data));

  p_default_lane0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (32'(req_index[7:0]) >= lim))
      |=> rsp_data[7:0] == $past(req_default[7:0]));

  p_default_lane7_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (32'(req_index[63:56]) >= lim))
      |=> rsp_data[63:56] == $past(req_default[63:56]));
endmodule

bind byte_perm_lookup byte_perm_lookup_chk #(
  .DESC_W(DESC_W), .LEN_W(LEN_W), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_desc(req_desc), .req_index(req_index), .req_default(req_default),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data)
);

// File: tb/byte_perm_lookup_tb.sv
module byte_perm_lookup_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_desc = '0;
  logic [63:0] req_index = '0;
  logic [63:0] req_default = '0;
  logic        rsp_valid;
  logic [63:0] rsp_data;

  logic [63:0] model [32];
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  byte_perm_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_desc(req_desc),
    .req_index(req_index), .req_default(req_default),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [63:0] expect_val(logic [6:0] d, logic [63:0] ix, logic [63:0] df);
    logic [63:0] r;
    int lim;
    lim = (int'(d[1:0]) + 1) * 8;
    for (int k = 0; k < 8; k++) begin
      int i;
      i = int'(ix[8*k +: 8]);
      if (i < lim)
        r[8*k +: 8] = model[(int'(d[6:2]) + i / 8) % 32][8*(i % 8) +: 8];
      else
        r[8*k +: 8] = df[8*k +: 8];
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [4:0] a, logic [63:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = v;
  endtask

  task automatic lookup(string req, logic [6:0] d, logic [63:0] ix, logic [63:0] df);
    logic [63:0] e;
    @(negedge clk);
    e = expect_val(d, ix, df);
    req_valid = 1'b1; req_desc = d; req_index = ix; req_default = df;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 64'(rsp_valid), 64'd1);
    check(req, rsp_data, e);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    check("R1 rsp_data in reset", rsp_data, 64'd0);
    check("R2 ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    lookup("R1 zero regs", {5'd3, 2'd3}, 64'h1f17_0f07_1810_0800, 64'hffff_ffff_ffff_ffff);

    for (int i = 0; i < 32; i++) write_reg(5'(i), {$urandom, $urandom});

    lookup("R5 identity len1", {5'd4, 2'd0}, 64'h0706_0504_0302_0100, 64'hAAAA_AAAA_AAAA_AAAA);
    lookup("R5 reverse len1", {5'd9, 2'd0}, 64'h0001_0203_0405_0607, 64'h0);
    lookup("R4 R6 limit len1", {5'd2, 2'd0}, 64'h0807_0807_0807_0807, 64'h1122_3344_5566_7788);
    lookup("R4 R6 limit len2", {5'd2, 2'd1}, 64'h100f_100f_100f_100f, 64'h1122_3344_5566_7788);
    lookup("R4 R6 limit len3", {5'd2, 2'd2}, 64'h1817_1817_1817_1817, 64'h1122_3344_5566_7788);
    lookup("R4 R6 limit len4", {5'd2, 2'd3}, 64'h201f_201f_201f_201f, 64'h1122_3344_5566_7788);
    lookup("R6 index 255", {5'd0, 2'd3}, 64'hff00_ff00_ff80_ff40, 64'hDEAD_BEEF_CAFE_F00D);
    lookup("R7 wrap base30", {5'd30, 2'd3}, 64'h0008_1018_1f17_0f07, 64'h0);
    lookup("R7 wrap base31", {5'd31, 2'd1}, 64'h0f0e_0d0c_0b0a_0908, 64'h0);

    // R8: write and lookup in the same cycle; lookup sees the old word
    @(negedge clk);
    begin
      logic [63:0] e;
      e = expect_val({5'd5, 2'd0}, 64'h0706_0504_0302_0100, 64'h0);
      wr_en = 1'b1; wr_addr = 5'd5; wr_data = 64'h0123_4567_89ab_cdef;
      req_valid = 1'b1; req_desc = {5'd5, 2'd0};
      req_index = 64'h0706_0504_0302_0100; req_default = 64'h0;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      model[5] = 64'h0123_4567_89ab_cdef;
      check("R8 same-cycle old data", rsp_data, e);
      @(negedge clk);
      check("R3 valid drops", 64'(rsp_valid), 64'd0);
      check("R9 data held", rsp_data, e);
    end
    lookup("R8 new data visible", {5'd5, 2'd0}, 64'h0706_0504_0302_0100, 64'h0);

    for (int n = 0; n < 300; n++) begin
      logic [63:0] ix;
      for (int k = 0; k < 8; k++) ix[8*k +: 8] = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 32);
      if (n % 10 == 0) write_reg(5'($urandom), {$urandom, $urandom});
      lookup("R5 R6 R7 random", 7'($urandom), ix, {$urandom, $urandom});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule